// File: doc/BRIEF.md
# Plug and Play Card Isolation Controller

This block is the card-side engine of ISA Plug and Play auto-configuration. It watches the bytes that host software writes to the shared address port and recognises a fixed 32-byte initiation key. The key is produced by an 8-bit shift register with feedback. Once the key is seen, the card leaves its dormant state and follows the host through the Sleep, Isolation and Config states. The host uses the same port to select an index register and uses a write-data port to issue card-control commands. These commands set the read-data port location, return to the dormant state or clear the card number, wake a card by number, and assign a card number.

Isolation runs in lock-step with host software, one identifier bit at a time. Each of the 72 identifier bits takes two reads of the read-data port, starting with bit 0. A card whose bit is 1 drives a fixed byte pair onto the bus. A card whose bit is 0 keeps off the bus and watches it. If it sees the pair, it knows that a competitor with a 1 exists and drops to Sleep. The one card that survives all 72 bits waits in Isolation until the host writes a card select number, then moves to Config.

Top module: `pnp_isolation_ctrl`

## Requirements
- R1: After reset the card is in Wait-for-Key (state code 0), the card number is 0, the read-data port selection is 0 and no read is driven.
- R2: In Wait-for-Key, 32 consecutive address-port writes equal to the key sequence move the card to Sleep (state code 1). The first key byte is 6Ah and each next byte is {b0 xor b1, b7..b1} of the previous one. A non-matching write restarts the comparison at the first byte and is not itself counted. Write-data port writes in this state are ignored.
- R3: A write to wake index 03h has these effects. In Sleep, a value of 0 with card number 0 moves the card to Isolation (state code 2) and restarts isolation at bit 0. In Sleep, a value equal to a non-zero card number moves the card to Config (state code 3). In Isolation or Config, a value different from the card number moves the card to Sleep. Any other wake write leaves the state unchanged.
- R4: In Isolation with index 01h, each identifier bit takes a pair of reads, starting with bit 0. For a 1 bit the card drives 55h and then AAh. For a 0 bit it drives nothing, and if the bus carries 55h on the first read and AAh on the second, it enters Sleep after the second read.
- R5: After all 72 bit pairs the card stays in Isolation and drives nothing on further index-01h reads.
- R6: A write to index 06h behaves as follows. In Isolation after all 72 pairs, it stores the card number and moves the card to Config. In Isolation before that, it is ignored. In Config, it replaces the card number.
- R7: In Isolation or Config, a read with index 06h drives the card number and a read with index 05h drives 01h. In Wait-for-Key or Sleep, and for any index other than 01h, 05h and 06h, no read is driven.
- R8: A write to control index 02h has two effects in any state but Wait-for-Key. Bit 2 clears the card number. Bit 1 returns the card to Wait-for-Key.
- R9: A write to index 00h in any state but Wait-for-Key sets the read-data port selection output.
- R10: When an address-port write and a read fall in the same cycle, the read is served under the previous index and the new index applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| serial_id | input | 72 | Card identifier, bit 0 sent first |
| addr_wr | input | 1 | Write strobe of the address (index) port |
| wdata_wr | input | 1 | Write strobe of the write-data port |
| rdata_rd | input | 1 | Read strobe of the read-data port |
| wr_data | input | 8 | Byte written with either write strobe |
| bus_in | input | 8 | Byte observed on the shared bus during a read |
| rd_drive | output | 1 | Card drives rd_data onto the bus this read |
| rd_data | output | 8 | Byte driven by the card |
| card_state | output | 2 | 0 Wait-for-Key, 1 Sleep, 2 Isolation, 3 Config |
| card_csn | output | 8 | Stored card select number |
| rdp_sel | output | 8 | Read-data port selection set through index 00h |

## Verification
An index change on the address port and an isolation read can occur in the same cycle. The bench issues both in one cycle during Isolation. It expects that read to carry the 55h half of the current bit pair under the old index. It expects the next read to return the card number under the new index. Restoring index 01h must then finish the same bit pair with AAh. The isolation sweep flips each identifier bit in turn in a modelled competitor, and the arithmetic outcome decides whether the card must end in Sleep or reach the end of the 72 pairs.

// File: rtl/pnp_iso_pkg.sv
`timescale 1ns/1ps
package pnp_iso_pkg;
  typedef enum logic [1:0] {
    ST_WAITKEY = 2'd0,
    ST_SLEEP   = 2'd1,
    ST_ISOLATE = 2'd2,
    ST_CONFIG  = 2'd3
  } card_st_e;

  localparam logic [7:0] IDX_RDPORT = 8'h00;
  localparam logic [7:0] IDX_ISOL   = 8'h01;
  localparam logic [7:0] IDX_CTRL   = 8'h02;
  localparam logic [7:0] IDX_WAKE   = 8'h03;
  localparam logic [7:0] IDX_STATUS = 8'h05;
  localparam logic [7:0] IDX_CSN    = 8'h06;

  localparam logic [7:0] ISO_FIRST  = 8'h55;
  localparam logic [7:0] ISO_SECOND = 8'hAA;
  localparam logic [7:0] STAT_READY = 8'h01;
endpackage

// File: rtl/pnp_key_match.sv
`timescale 1ns/1ps
module pnp_key_match #(
  parameter int         KEY_LEN  = 32,
  parameter logic [7:0] KEY_SEED = 8'h6A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       armed,
  input  logic       wr_en,
  input  logic [7:0] wr_byte,
  output logic       key_hit
);
  localparam int CW = $clog2(KEY_LEN);
  localparam logic [CW-1:0] LAST = CW'(KEY_LEN - 1);

  logic [7:0]    lfsr_q, lfsr_d;
  logic [CW-1:0] pos_q, pos_d;

  always_comb begin
    lfsr_d  = lfsr_q;
    pos_d   = pos_q;
    key_hit = 1'b0;
    if (!armed) begin
      lfsr_d = KEY_SEED;
      pos_d  = '0;
    end else if (wr_en) begin
      if (wr_byte == lfsr_q) begin
        if (pos_q == LAST) begin
          key_hit = 1'b1;
          lfsr_d  = KEY_SEED;
          pos_d   = '0;
        end else begin
          lfsr_d = {lfsr_q[0] ^ lfsr_q[1], lfsr_q[7:1]};
          pos_d  = pos_q + 1'b1;
        end
      end else begin
        lfsr_d = KEY_SEED;
        pos_d  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= KEY_SEED;
      pos_q  <= '0;
    end else begin
      lfsr_q <= lfsr_d;
      pos_q  <= pos_d;
    end
  end

  AST_KEY_HIT_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    key_hit |-> (wr_en && armed)); // R2
  AST_KEY_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !wr_en) |=> $stable(pos_q)); // R2
endmodule

// File: rtl/pnp_iso_arb.sv
`timescale 1ns/1ps
module pnp_iso_arb
  import pnp_iso_pkg::*;
#(
  parameter int ID_BITS = 72
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               rd_en,
  input  logic [ID_BITS-1:0] serial_id,
  input  logic [7:0]         bus_in,
  output logic               drive,
  output logic [7:0]         drv_val,
  output logic               lose,
  output logic               done
);
  localparam int BW = $clog2(ID_BITS);
  localparam logic [BW-1:0] LAST = BW'(ID_BITS - 1);

  logic [BW-1:0] bit_q, bit_d;
  logic          phase_q, phase_d;
  logic          seen_q, seen_d;
  logic          done_q, done_d;
  logic          my_bit, active;

  assign my_bit  = serial_id[bit_q];
  assign active  = rd_en && !done_q;
  assign drive   = active && my_bit;
  assign drv_val = phase_q ? ISO_SECOND : ISO_FIRST;
  assign lose    = active && phase_q && !my_bit && seen_q && (bus_in == ISO_SECOND);
  assign done    = done_q;

  always_comb begin
    bit_d   = bit_q;
    phase_d = phase_q;
    seen_d  = seen_q;
    done_d  = done_q;
    if (restart) begin
      bit_d   = '0;
      phase_d = 1'b0;
      seen_d  = 1'b0;
      done_d  = 1'b0;
    end else if (active) begin
      if (!phase_q) begin
        phase_d = 1'b1;
        seen_d  = !my_bit && (bus_in == ISO_FIRST);
      end else begin
        phase_d = 1'b0;
        seen_d  = 1'b0;
        if (bit_q == LAST) done_d = 1'b1;
        else               bit_d  = bit_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q   <= '0;
      phase_q <= 1'b0;
      seen_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      bit_q   <= bit_d;
      phase_q <= phase_d;
      seen_q  <= seen_d;
      done_q  <= done_d;
    end
  end

  AST_ISO_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !restart) |=> done_q); // R5
  AST_ISO_PAIR_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !restart) |=> (phase_q != $past(phase_q))); // R4
  AST_ISO_LOSE_SECOND_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    lose |-> (phase_q && !drive)); // R4
endmodule

// File: rtl/pnp_card_regs.sv
`timescale 1ns/1ps
module pnp_card_regs
  import pnp_iso_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_wr,
  input  logic       wdata_wr,
  input  logic [7:0] wr_byte,
  input  logic       key_hit,
  input  logic       iso_lose,
  input  logic       iso_done,
  output card_st_e   state,
  output logic [7:0] index,
  output logic [7:0] csn,
  output logic [7:0] rdp_sel,
  output logic       iso_restart
);
  card_st_e   st_q, st_d;
  logic [7:0] idx_q, idx_d;
  logic [7:0] csn_q, csn_d;
  logic [7:0] rdp_q, rdp_d;

  always_comb begin
    st_d        = st_q;
    idx_d       = idx_q;
    csn_d       = csn_q;
    rdp_d       = rdp_q;
    iso_restart = 1'b0;
    if (st_q == ST_WAITKEY) begin
      if (key_hit) st_d = ST_SLEEP;
    end else begin
      if (iso_lose) st_d = ST_SLEEP;
      if (wdata_wr) begin
        case (idx_q)
          IDX_RDPORT: rdp_d = wr_byte;
          IDX_CTRL: begin
            if (wr_byte[2]) csn_d = '0;
            if (wr_byte[1]) st_d  = ST_WAITKEY;
          end
          IDX_WAKE: begin
            if (st_q == ST_SLEEP) begin
              if (wr_byte == csn_q) begin
                if (wr_byte == 8'h00) begin
                  st_d        = ST_ISOLATE;
                  iso_restart = 1'b1;
                end else begin
                  st_d = ST_CONFIG;
                end
              end
            end else if (wr_byte != csn_q) begin
              st_d = ST_SLEEP;
            end
          end
          IDX_CSN: begin
            if (st_q == ST_CONFIG) begin
              csn_d = wr_byte;
            end else if (st_q == ST_ISOLATE && iso_done) begin
              csn_d = wr_byte;
              st_d  = ST_CONFIG;
            end
          end
          default: ;
        endcase
      end
      if (addr_wr) idx_d = wr_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_WAITKEY;
      idx_q <= '0;
      csn_q <= '0;
      rdp_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      csn_q <= csn_d;
      rdp_q <= rdp_d;
    end
  end

  assign state   = st_q;
  assign index   = idx_q;
  assign csn     = csn_q;
  assign rdp_sel = rdp_q;

  AST_KEY_EXITS_TO_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAITKEY) |=> (st_q == ST_WAITKEY || st_q == ST_SLEEP)); // R2
  AST_WAITKEY_CSN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAITKEY) |=> $stable(csn_q)); // R2
  AST_CSN_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ISOLATE && !iso_done) |=> (st_q != ST_CONFIG)); // R6
endmodule

// File: rtl/pnp_isolation_ctrl.sv
`timescale 1ns/1ps
module pnp_isolation_ctrl
  import pnp_iso_pkg::*;
#(
  parameter int         ID_BITS  = 72,
  parameter int         KEY_LEN  = 32,
  parameter logic [7:0] KEY_SEED = 8'h6A
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ID_BITS-1:0] serial_id,
  input  logic               addr_wr,
  input  logic               wdata_wr,
  input  logic               rdata_rd,
  input  logic [7:0]         wr_data,
  input  logic [7:0]         bus_in,
  output logic               rd_drive,
  output logic [7:0]         rd_data,
  output logic [1:0]         card_state,
  output logic [7:0]         card_csn,
  output logic [7:0]         rdp_sel
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  card_st_e   st;
  logic [7:0] idx, csn;
  logic       key_hit, iso_restart, iso_rd, iso_drive, iso_lose, iso_done;
  logic [7:0] iso_val;
  logic       reg_rd;

  pnp_key_match #(.KEY_LEN(KEY_LEN), .KEY_SEED(KEY_SEED)) u_key (
    .clk(clk), .rst_n(rst_int_n), .armed(st == ST_WAITKEY),
    .wr_en(addr_wr), .wr_byte(wr_data), .key_hit(key_hit)
  );

  pnp_card_regs u_regs (
    .clk(clk), .rst_n(rst_int_n), .addr_wr(addr_wr), .wdata_wr(wdata_wr),
    .wr_byte(wr_data), .key_hit(key_hit), .iso_lose(iso_lose),
    .iso_done(iso_done), .state(st), .index(idx), .csn(csn),
    .rdp_sel(rdp_sel), .iso_restart(iso_restart)
  );

  assign iso_rd = rdata_rd && (st == ST_ISOLATE) && (idx == IDX_ISOL);

  pnp_iso_arb #(.ID_BITS(ID_BITS)) u_iso (
    .clk(clk), .rst_n(rst_int_n), .restart(iso_restart), .rd_en(iso_rd),
    .serial_id(serial_id), .bus_in(bus_in), .drive(iso_drive),
    .drv_val(iso_val), .lose(iso_lose), .done(iso_done)
  );

  assign reg_rd = rdata_rd && (st == ST_ISOLATE || st == ST_CONFIG) &&
                  (idx == IDX_STATUS || idx == IDX_CSN);

  always_comb begin
    rd_drive = iso_drive || reg_rd;
    rd_data  = 8'h00;
    if (iso_drive)   rd_data = iso_val;
    else if (reg_rd) rd_data = (idx == IDX_CSN) ? csn : STAT_READY;
  end

  assign card_state = st;
  assign card_csn   = csn;

  AST_QUIET_WHEN_DORMANT: assert property (@(posedge clk) disable iff (!rst_int_n)
    (st == ST_WAITKEY || st == ST_SLEEP) |-> !rd_drive); // R7
  AST_DRIVE_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_drive |-> rdata_rd); // R7
endmodule

// File: tb/test_pnp_isolation_ctrl.sv
`timescale 1ns/1ps
module test_pnp_isolation_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [71:0] MY_ID = 72'hC3_5A96_0F1E_2D3C_4B78;

  logic        clk, rst_n;
  logic        addr_wr, wdata_wr, rdata_rd;
  logic [7:0]  wr_data, bus_in;
  logic        rd_drive;
  logic [7:0]  rd_data, card_csn, rdp_sel;
  logic [1:0]  card_state;

  int n_checks, n_fails;
  logic       s_drv;
  logic [7:0] s_dat;

  pnp_isolation_ctrl i_pnp_isolation_ctrl (
    .clk(clk), .rst_n(rst_n), .serial_id(MY_ID), .addr_wr(addr_wr),
    .wdata_wr(wdata_wr), .rdata_rd(rdata_rd), .wr_data(wr_data),
    .bus_in(bus_in), .rd_drive(rd_drive), .rd_data(rd_data),
    .card_state(card_state), .card_csn(card_csn), .rdp_sel(rdp_sel)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic aw, input logic dw, input logic rr,
                     input logic [7:0] wd, input logic [7:0] bus);
    @(negedge clk);
    addr_wr = aw; wdata_wr = dw; rdata_rd = rr; wr_data = wd; bus_in = bus;
    #1;
    s_drv = rd_drive;
    s_dat = rd_data;
    @(posedge clk);
    #1;
    addr_wr = 1'b0; wdata_wr = 1'b0; rdata_rd = 1'b0;
  endtask

  task automatic awr(input logic [7:0] b); cyc(1'b1, 1'b0, 1'b0, b, 8'hFF); endtask
  task automatic dwr(input logic [7:0] b); cyc(1'b0, 1'b1, 1'b0, b, 8'hFF); endtask
  task automatic rd(input logic [7:0] bus); cyc(1'b0, 1'b0, 1'b1, 8'h00, bus); endtask

  function automatic logic [7:0] key_next(input logic [7:0] b);
    return {b[0] ^ b[1], b[7:1]};
  endfunction

  task automatic send_key();
    logic [7:0] k;
    k = 8'h6A;
    for (int i = 0; i < 32; i++) begin
      awr(k);
      k = key_next(k);
    end
  endtask

  task automatic enter_iso();
    if (card_state != 2'd0) begin
      awr(8'h02); dwr(8'h06);
    end
    send_key();
    awr(8'h03); dwr(8'h00);
    awr(8'h01);
  endtask

  // Runs up to 72 bit pairs against a modelled competitor; returns lost bit or -1.
  task automatic run_iso(input logic [71:0] comp, output int lost_at);
    logic comp_in;
    comp_in = 1'b1;
    lost_at = -1;
    for (int i = 0; i < 72; i++) begin
      rd((comp_in && comp[i]) ? 8'h55 : 8'hFF);
      check("R4 first read drive", int'(s_drv), int'(MY_ID[i]));
      if (MY_ID[i]) check("R4 first read byte", int'(s_dat), 8'h55);
      rd((comp_in && comp[i]) ? 8'hAA : 8'hFF);
      check("R4 second read drive", int'(s_drv), int'(MY_ID[i]));
      if (MY_ID[i]) check("R4 second read byte", int'(s_dat), 8'hAA);
      if (!MY_ID[i] && comp_in && comp[i]) begin
        lost_at = i;
        break;
      end
      if (MY_ID[i] && !comp[i]) comp_in = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    int lost;
    logic [7:0] k;
    logic [7:0] last_csn;
    n_checks = 0; n_fails = 0;
    addr_wr = 0; wdata_wr = 0; rdata_rd = 0; wr_data = 0; bus_in = 8'hFF;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    check("R1 state", int'(card_state), 0);
    check("R1 csn", int'(card_csn), 0);
    check("R1 rdp_sel", int'(rdp_sel), 0);
    rd(8'hFF);
    check("R1 no drive", int'(s_drv), 0);

    // R2 broken key, ignored data write
    dwr(8'h5C);
    check("R2 data write ignored in wait", int'(card_csn), 0);
    k = 8'h6A;
    for (int i = 0; i < 32; i++) begin
      awr(i == 10 ? 8'h00 : k);
      k = key_next(k);
    end
    check("R2 broken key stays", int'(card_state), 0);
    send_key();
    check("R2 key reaches sleep", int'(card_state), 1);
    rd(8'hFF);
    check("R7 sleep no drive", int'(s_drv), 0);

    // R3 wake zero -> isolation
    awr(8'h03); dwr(8'h00);
    check("R3 wake zero to isolation", int'(card_state), 2);

    // R10 same-cycle index write and isolation read
    awr(8'h01);
    cyc(1'b1, 1'b0, 1'b1, 8'h06, 8'hFF);
    check("R10 read under old index drive", int'(s_drv), int'(MY_ID[0]));
    check("R10 read under old index byte", int'(s_dat), MY_ID[0] ? 8'h55 : 8'h00);
    rd(8'hFF);
    check("R10 new index applies", int'(s_drv), 1);
    check("R7 csn read in isolation", int'(s_dat), 0);
    awr(8'h01);
    rd(8'hFF);
    check("R10 pair completes drive", int'(s_drv), int'(MY_ID[0]));
    if (MY_ID[0]) check("R10 pair completes byte", int'(s_dat), 8'hAA);

    // R6 early csn write ignored
    awr(8'h06); dwr(8'h44);
    check("R6 early csn state", int'(card_state), 2);
    check("R6 early csn value", int'(card_csn), 0);

    // R4/R5/R6 sweep: competitor differs first at bit b
    for (int b = 0; b < 72; b++) begin
      enter_iso();
      check("R3 sweep isolation entry", int'(card_state), 2);
      run_iso(MY_ID ^ (72'd1 << b), lost);
      if (!MY_ID[b]) begin
        check("R4 loses at flipped bit", lost, b);
        check("R4 loser sleeps", int'(card_state), 1);
      end else begin
        check("R4 winner survives", lost, -1);
        check("R5 winner still isolating", int'(card_state), 2);
        rd(8'h55); rd(8'hAA);
        check("R5 no drive after done", int'(s_drv), 0);
        check("R5 state after extra reads", int'(card_state), 2);
        awr(8'h06); dwr(8'(b + 1));
        check("R6 csn write enters config", int'(card_state), 3);
        check("R6 csn stored", int'(card_csn), b + 1);
      end
    end

    // card ends in config (bit 71 of MY_ID is 1)
    last_csn = card_csn;
    awr(8'h06); rd(8'hFF);
    check("R7 csn read drive", int'(s_drv), 1);
    check("R7 csn read byte", int'(s_dat), int'(last_csn));
    awr(8'h05); rd(8'hFF);
    check("R7 status read", int'(s_dat), 8'h01);
    awr(8'h09); rd(8'hFF);
    check("R7 other index no drive", int'(s_drv), 0);
    awr(8'h06); dwr(8'h3B);
    check("R6 csn rewrite in config", int'(card_csn), 8'h3B);

    // R9 read-data port selection
    awr(8'h00); dwr(8'h27);
    check("R9 rdp_sel", int'(rdp_sel), 8'h27);

    // R3 wake mismatch, wake zero with number, wake match
    awr(8'h03); dwr(8'h3C);
    check("R3 mismatch sleeps", int'(card_state), 1);
    dwr(8'h00);
    check("R3 wake zero with number ignored", int'(card_state), 1);
    dwr(8'h3B);
    check("R3 matching wake to config", int'(card_state), 3);

    // R8 config control
    awr(8'h02); dwr(8'h04);
    check("R8 csn cleared", int'(card_csn), 0);
    check("R8 state kept", int'(card_state), 3);
    dwr(8'h02);
    check("R8 return to wait", int'(card_state), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule